// File: doc/BRIEF.md
# Edge-Count Event Counter

This block counts transitions on an asynchronous input pin. It raises a flag once a programmed number of qualifying transitions has been seen. The pin is first brought into the clock domain by a synchronizer. Each transition of the chosen polarity then moves a 24-bit count by one step. The count is built from a 16-bit main part and an 8-bit extension, and every compare uses the whole 24-bit value.

Two directions are supported. Counting up runs from zero to the match value and then wraps back to zero. Counting down starts from a start value and falls toward the match value. It then reloads the start value and halts until the enable input is dropped and raised again.

Software sets the start value, the match value, the direction, the edge polarity and the interrupt mask through a small write port. The same port clears the flag. The live count and the interrupt line are plain outputs.

Top module: `edge_event_counter`

## Requirements
- R1: The pin passes through a two-flop synchronizer. A qualifying transition on the pin changes `count` on the third rising clock edge after it, and each qualifying transition moves the count by exactly one.
- R2: Control bits [2:1] select the edge polarity: 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both.
- R3: With control bit 0 clear (up), a rising `en` loads `count` with 0. Each event then increments it. An increment that would reach the match value instead sets `count` to 0 and sets the flag.
- R4: With control bit 0 set (down), a rising `en` loads `count` with the start value. Each event then decrements it. A decrement that would reach the match value instead reloads the start value and sets the flag, so one pass takes start minus match events.
- R5: In down mode, after the match the counter ignores every further event. It counts again only after `en` has been low and then high again.
- R6: The flag stays set until a write to address 3 with data bit 0 set clears it. A match in the same cycle as that write wins over the clear.
- R7: `irq` equals the flag ANDed with control bit 3 (mask). A flag set while the mask is off appears on `irq` as soon as the mask is set.
- R8: While `en` is low, `count` holds its value and input transitions have no effect.
- R9: Writes go to address 0 (start value), address 1 (match value) and address 2 (control). They take effect on the clock edge of the write, and the count step in that same cycle still uses the old settings.
- R10: After reset, `count` is 0, `irq` is 0 and all settings are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter enable; a rising level reloads the count |
| pin_async | input | 1 | External event input, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 start, 1 match, 2 control, 3 flag clear |
| wr_data | input | 24 | Write data |
| count | output | 24 | Current count value |
| irq | output | 1 | Masked match flag |

## Verification
The pin is driven with pulse trains under each of the three polarity settings. The resulting counts differ between rising-only, falling-only and both-edge counting, so each setting is told apart from the others. Down-counting runs continue past the match. This separates a counter that halts from one that keeps counting, and a second enable pulse shows that counting resumes. Pulses are also sent while `en` is low, and a match is reached with the mask off. These two runs separate edges that are really ignored from ones that leak through, and a hidden flag from one that was never set.

// File: rtl/edge_event_counter.sv
module edge_event_counter #(
  parameter int CNT_W = 16,
  parameter int EXT_W = 8,
  parameter int TOT_W = CNT_W + EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pin_async,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TOT_W-1:0] wr_data,
  output logic [TOT_W-1:0] count,
  output logic             irq
);

  logic [2:0]       sy;
  logic [TOT_W-1:0] start_r, match_r, nxt;
  logic             down_r, mask_r, en_q, halted, flag;
  logic [1:0]       esel;
  logic             rise, fall, evt, arm, step, hit, clr;

  assign rise = sy[1] & ~sy[2];
  assign fall = ~sy[1] & sy[2];
  assign evt  = esel[1] ? (rise | fall) : (esel[0] ? fall : rise);
  assign arm  = en & ~en_q;
  assign step = en & en_q & ~halted & evt;
  assign nxt  = down_r ? count - 1'b1 : count + 1'b1;
  assign hit  = step && (nxt == match_r);
  assign clr  = wr_en && (wr_addr == 2'd3) && wr_data[0];
  assign irq  = flag & mask_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], pin_async};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_r <= '0;
      match_r <= '0;
      down_r  <= 1'b0;
      esel    <= 2'b00;
      mask_r  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: start_r <= wr_data;
        2'd1: match_r <= wr_data;
        2'd2: {mask_r, esel, down_r} <= wr_data[3:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count  <= '0;
      en_q   <= 1'b0;
      halted <= 1'b0;
      flag   <= 1'b0;
    end else begin
      en_q <= en;
      flag <= hit | (flag & ~clr);
      if (arm)
        count <= down_r ? start_r : '0;
      else if (step)
        count <= hit ? (down_r ? start_r : '0) : nxt;
      if (!en || arm)         halted <= 1'b0;
      else if (hit && down_r) halted <= 1'b1;
    end

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  p_no_event_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q && !evt) |=> $stable(count));

  p_halt_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && en && en_q) |=> $stable(count));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  p_reload_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (count == ($past(down_r) ? $past(start_r) : '0)));

  p_down_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && down_r) |=> halted);

endmodule

// File: tb/sim_edge_event_counter.sv
`timescale 1ns/1ps
module sim_edge_event_counter;
  logic        clk = 0, rst_n = 0, en = 0, pin = 0, wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [23:0] wr_data = 0;
  logic [23:0] count;
  logic        irq;
  int tests = 0, fails = 0;
  string phase = "R10";

  always #4 clk = ~clk;

  edge_event_counter u0 (.clk(clk), .rst_n(rst_n), .en(en), .pin_async(pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .irq(irq));

  // behavioural reference
  logic hist[$];
  int   m_cnt, m_start, m_match;
  bit   m_down, m_mask, m_en_prev, m_stopped, m_flag;
  bit [1:0] m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_cnt = 0; m_start = 0; m_match = 0; m_down = 0; m_mask = 0;
      m_sel = 0; m_en_prev = 0; m_stopped = 0; m_flag = 0;
    end else begin
      bit now_v, old_v, e, matched;
      int tgt;
      now_v = hist[1]; old_v = hist[2];
      e = (m_sel[1] && now_v != old_v) ||
          (m_sel == 2'b00 && now_v && !old_v) ||
          (m_sel == 2'b01 && !now_v && old_v);
      matched = 0;
      if (en && !m_en_prev) begin
        m_cnt = m_down ? m_start : 0;
        m_stopped = 0;
      end else if (en && e && !m_stopped) begin
        tgt = m_down ? ((m_cnt - 1) & 24'hffffff) : ((m_cnt + 1) & 24'hffffff);
        if (tgt == m_match) begin
          matched = 1;
          m_cnt = m_down ? m_start : 0;
          if (m_down) m_stopped = 1;
        end else m_cnt = tgt;
      end
      if (!en) m_stopped = 0;
      if (wr_en && wr_addr == 3 && wr_data[0]) m_flag = 0;
      if (matched) m_flag = 1;
      if (wr_en && wr_addr == 0) m_start = wr_data;
      if (wr_en && wr_addr == 1) m_match = wr_data;
      if (wr_en && wr_addr == 2) {m_mask, m_sel, m_down} = wr_data[3:0];
      m_en_prev = en;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk({phase, " count"}, count, m_cnt);
    chk({phase, " irq"}, irq, m_flag & m_mask);
  end

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1; repeat (3) @(negedge clk);
      pin = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic enable(input bit v);
    @(negedge clk); en = v; repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset count", count, 0);
    chk("R10 reset irq", irq, 0);

    phase = "R3";
    wr(1, 3); wr(2, 4'b1000);
    enable(1);
    pulses(2);
    chk("R3 up two events", count, 2);
    chk("R3 no irq yet", irq, 0);
    pulses(1);
    chk("R3 wrap to zero", count, 0);
    chk("R3 flag on irq", irq, 1);

    phase = "R6";
    wr(3, 1);
    chk("R6 clear", irq, 0);

    phase = "R2";
    enable(0);
    wr(1, 100); wr(2, 4'b1010);
    enable(1);
    chk("R3 reload zero", count, 0);
    pulses(1);
    chk("R2 falling only", count, 1);
    wr(2, 4'b1100);
    pulses(1);
    chk("R2 both edges", count, 3);
    wr(2, 4'b1110);
    pulses(2);
    chk("R2 both code 11", count, 7);

    phase = "R4";
    enable(0);
    wr(0, 24'h010005); wr(1, 24'h010002); wr(2, 4'b1001);
    enable(1);
    chk("R4 load start", count, 24'h010005);
    pulses(2);
    chk("R4 down two events", count, 24'h010003);
    pulses(1);
    chk("R4 reload start", count, 24'h010005);
    chk("R4 flag on irq", irq, 1);

    phase = "R5";
    pulses(3);
    chk("R5 halted after match", count, 24'h010005);
    wr(3, 1);
    enable(0); enable(1);
    pulses(1);
    chk("R5 resumed", count, 24'h010004);

    phase = "R7";
    wr(2, 4'b0001);
    pulses(2);
    chk("R7 reload while masked", count, 24'h010005);
    chk("R7 masked irq low", irq, 0);
    wr(2, 4'b1001);
    chk("R7 unmask shows flag", irq, 1);
    wr(3, 1);

    phase = "R8";
    enable(0);
    pulses(3);
    chk("R8 held while disabled", count, 24'h010005);

    phase = "R9";
    wr(0, 24'h000400); wr(1, 24'h0003fe);
    chk("R9 write does not move count", count, 24'h010005);
    enable(1);
    chk("R9 new start loaded", count, 24'h000400);
    pulses(2);
    chk("R9 new match used", irq, 1);

    phase = "R1";
    wr(3, 1);
    enable(0);
    wr(0, 0); wr(1, 50); wr(2, 4'b1000);
    enable(1);
    @(negedge clk); pin = 1;
    @(negedge clk); chk("R1 edge after 1 clk", count, 0);
    @(negedge clk); chk("R1 edge after 2 clk", count, 0);
    @(negedge clk); chk("R1 edge after 3 clk", count, 1);
    repeat (3) @(negedge clk); pin = 0;
    repeat (5) @(negedge clk);
    chk("R1 single step", count, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule